// File: doc/BRIEF.md
# NAND Flash Command and Address Front End

This block is the device-side bus interface of a small-page NAND flash model with an 8-bit I/O bus. It samples the latch-enable lines, the chip enable and the write-protect pin on every cycle that carries a write strobe. It decodes command bytes and builds a multi-byte address from successive address cycles. It decides when an operation may begin, and then sends a one-cycle start pulse to a separate array engine. That pulse carries the assembled address and a column offset.

Three pointer commands all lead to an ordinary page read, each with its own preset column offset: from the start of the page, from the second half, or from the spare area. Status and identification queries are answered by this block itself, with no help from the engine. A status query keeps returning the live status byte until another command arrives. An identification query yields a fixed four-byte sequence. The engine reports back through completion and failure inputs, and these drive the ready and error bits of the status byte.

Top module: `nand_cmd_frontend`

## Requirements
- R1: A write-strobed byte is decoded as a command only while ce_ni is low and cle_i is high; a byte offered with ce_ni high, or with no strobe, leaves the mode unchanged.
- R2: Command 0x00 selects read mode with column offset 0, 0x01 selects read mode with offset 0x100, and 0x50 selects read mode with offset PAGE_SIZE. The offset appears on op_col_o together with start_read_o. In read mode each data read returns buf_data_i.
- R3: Each address cycle stores its byte at bit position 8 times the number of address cycles already received, so the first byte is least significant. Latching any command sets that count back to zero.
- R4: In read mode, start_read_o is high for exactly one cycle, in the cycle after the strobe of the third address cycle. At the same time op_addr_o carries all bytes received so far.
- R5: After command 0x90 and one address cycle, successive data reads return MFR_ID, DEV_ID, ID_FILL and 0xC0, and then 0x00.
- R6: The status byte has bit 7 equal to the current wp_ni level, bit 6 ready, bit 0 error, and all other bits 0.
- R7: After command 0x70, every data read returns the status byte again until another command is latched.
- R8: Command 0x10 pulses start_program_o, and command 0xD0 pulses start_erase_o, one cycle after the strobe, but only if wp_ni is high. With wp_ni low, neither command starts anything and the ready bit is unchanged. Pulse flag encoding in the bench: bit 0 read, bit 1 program, bit 2 erase.
- R9: On command 0xD0, the address bytes beyond the received cycle count are cleared, and the result shifted left by 8 bits is driven on op_addr_o.
- R10: Command 0xFF returns the block to read mode with offset 0, clears the address and cycle count, clears the error bit and sets the ready bit. Asynchronous reset leaves the same state, with io_o and all start pulses low.
- R11: A data read while ce_ni is high returns 0x00 and does not advance the identification sequence.
- R12: A program or erase start clears the ready bit. op_done_i sets it again, and op_fail_i sets the error bit. A 0xFF command latched in the same cycle as op_fail_i wins, leaving error clear and ready set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| wp_ni | input | 1 | Write protect, active low |
| we_i | input | 1 | Write strobe for io_i in this cycle |
| re_i | input | 1 | Data-output read strobe |
| io_i | input | 8 | Command, address or data byte in |
| io_o | output | 8 | Data byte out, valid the cycle after a read strobe |
| buf_data_i | input | 8 | Page buffer byte from the array engine |
| buf_rd_o | output | 1 | Read-mode data read, advances the engine's pointer |
| op_done_i | input | 1 | Engine finished a program or erase |
| op_fail_i | input | 1 | Engine reports a failed operation |
| start_read_o | output | 1 | One-cycle read start |
| start_program_o | output | 1 | One-cycle program start |
| start_erase_o | output | 1 | One-cycle erase start |
| op_addr_o | output | 32 | Address carried with a start pulse |
| op_col_o | output | 10 | Column offset carried with a start pulse |

## Verification
Two events that update the status register can arrive on the same clock edge: a reset command from the bus and a failure report from the engine. The bench drives 0xFF with op_fail_i high in a single cycle. It then issues a status query and expects 0xC0, with error clear and ready set, which shows that the reset command has priority. A second overlap involves the live protect bit. wp_ni is toggled between repeated status reads without any new command, and bit 7 must follow the pin on each read.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  localparam logic [7:0] CMD_RD_LO    = 8'h00;
  localparam logic [7:0] CMD_RD_HI    = 8'h01;
  localparam logic [7:0] CMD_RD_SPARE = 8'h50;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_STAT     = 8'h70;
  localparam logic [7:0] CMD_PG_SETUP = 8'h80;
  localparam logic [7:0] CMD_PG_GO    = 8'h10;
  localparam logic [7:0] CMD_ER_SETUP = 8'h60;
  localparam logic [7:0] CMD_ER_GO    = 8'hD0;
  localparam logic [7:0] CMD_RST      = 8'hFF;

  localparam logic [7:0] ID_TAIL_SMALL = 8'hC0;

  typedef enum logic [2:0] {
    MD_READ, MD_IDENT, MD_STAT, MD_PROG, MD_ERASE, MD_IDLE
  } fe_mode_e;
endpackage

// File: rtl/nand_fe_addr.sv
module nand_fe_addr #(
  parameter int NBYTES = 4,
  localparam int AW    = 8 * NBYTES,
  localparam int CNT_W = $clog2(NBYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic [7:0]       byte_i,
  output logic [AW-1:0]    addr_o,
  output logic [AW-1:0]    addr_nxt_o,
  output logic [AW-1:0]    addr_masked_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic [7:0] lane_q;
    logic       hit;
    assign hit = load_i && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lane_q <= '0;
      else if (clr_i)  lane_q <= '0;
      else if (hit)    lane_q <= byte_i;
    end
    assign addr_o[8*i +: 8]        = lane_q;
    assign addr_nxt_o[8*i +: 8]    = hit ? byte_i : lane_q;
    assign addr_masked_o[8*i +: 8] = (CNT_W'(i) < cnt_q) ? lane_q : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    cnt_q <= '0;
    else if (clr_i || restart_i)                    cnt_q <= '0;
    else if (load_i && cnt_q != CNT_W'(NBYTES))     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/nand_fe_status.sv
module nand_fe_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       busy_i,
  input  logic       done_i,
  input  logic       fail_i,
  input  logic       wp_ni,
  output logic [7:0] status_o
);
  logic ready_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      err_q   <= 1'b0;
    end else if (clr_i) begin
      ready_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      if (busy_i)      ready_q <= 1'b0;
      else if (done_i) ready_q <= 1'b1;
      if (fail_i)      err_q   <= 1'b1;
    end
  end

  // protect bit is live, never stored
  assign status_o = {wp_ni, ready_q, 5'b00000, err_q};
endmodule

// File: rtl/nand_fe_idseq.sv
module nand_fe_idseq #(
  parameter logic [7:0] MFR  = 8'hEC,
  parameter logic [7:0] DEV  = 8'h73,
  parameter logic [7:0] FILL = 8'hA5,
  parameter logic [7:0] TAIL = 8'hC0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       load_i,
  input  logic       adv_i,
  output logic [7:0] byte_o
);
  logic [2:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      left_q <= '0;
    else if (clr_i)                   left_q <= '0;
    else if (load_i)                  left_q <= 3'd4;
    else if (adv_i && left_q != '0)   left_q <= left_q - 1'b1;
  end

  always_comb begin
    unique case (left_q)
      3'd4:    byte_o = MFR;
      3'd3:    byte_o = DEV;
      3'd2:    byte_o = FILL;
      3'd1:    byte_o = TAIL;
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_cmd_frontend.sv
module nand_cmd_frontend
  import nand_fe_pkg::*;
#(
  parameter logic [7:0] MFR_ID      = 8'hEC,
  parameter logic [7:0] DEV_ID      = 8'h73,
  parameter logic [7:0] ID_FILL     = 8'hA5,
  parameter int         PAGE_SIZE   = 512,
  parameter int         ADDR_CYCLES = 3,
  localparam int        NBYTES      = ADDR_CYCLES + 1,
  localparam int        AW          = 8 * NBYTES,
  localparam int        COL_W       = $clog2(PAGE_SIZE) + 1,
  localparam int        CNT_W       = $clog2(NBYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             cle_i,
  input  logic             ale_i,
  input  logic             wp_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [7:0]       io_i,
  output logic [7:0]       io_o,
  input  logic [7:0]       buf_data_i,
  output logic             buf_rd_o,
  input  logic             op_done_i,
  input  logic             op_fail_i,
  output logic             start_read_o,
  output logic             start_program_o,
  output logic             start_erase_o,
  output logic [AW-1:0]    op_addr_o,
  output logic [COL_W-1:0] op_col_o
);
  fe_mode_e         mode_q;
  logic [COL_W-1:0] col_q;
  logic             cmd_stb, adr_stb, rd_en, stat_rd, is_rst;
  logic             go_read, go_prog, go_erase;
  logic [AW-1:0]    addr_cur, addr_nxt, addr_msk;
  logic [CNT_W-1:0] addr_cnt;
  logic [7:0]       status, id_byte, rd_val;

  assign cmd_stb = we_i && !ce_ni && cle_i;
  assign adr_stb = we_i && !ce_ni && ale_i && !cle_i;
  assign rd_en   = re_i && !ce_ni && !cle_i && !ale_i;
  assign stat_rd = rd_en && mode_q == MD_STAT;
  assign is_rst  = cmd_stb && io_i == CMD_RST;

  assign go_read  = adr_stb && mode_q == MD_READ && addr_cnt == CNT_W'(ADDR_CYCLES - 1);
  assign go_prog  = cmd_stb && io_i == CMD_PG_GO && wp_ni;
  assign go_erase = cmd_stb && io_i == CMD_ER_GO && wp_ni;

  nand_fe_addr #(.NBYTES(NBYTES)) u_addr (
    .clk_i, .rst_ni,
    .clr_i        (is_rst),
    .restart_i    (cmd_stb),
    .load_i       (adr_stb),
    .byte_i       (io_i),
    .addr_o       (addr_cur),
    .addr_nxt_o   (addr_nxt),
    .addr_masked_o(addr_msk),
    .cnt_o        (addr_cnt)
  );

  nand_fe_status u_stat (
    .clk_i, .rst_ni,
    .clr_i   (is_rst),
    .busy_i  (go_prog || go_erase),
    .done_i  (op_done_i),
    .fail_i  (op_fail_i),
    .wp_ni   (wp_ni),
    .status_o(status)
  );

  nand_fe_idseq #(.MFR(MFR_ID), .DEV(DEV_ID), .FILL(ID_FILL), .TAIL(ID_TAIL_SMALL)) u_id (
    .clk_i, .rst_ni,
    .clr_i (cmd_stb),
    .load_i(adr_stb && mode_q == MD_IDENT && addr_cnt == '0),
    .adv_i (rd_en && mode_q == MD_IDENT),
    .byte_o(id_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_READ;
      col_q  <= '0;
    end else if (cmd_stb) begin
      unique case (io_i)
        CMD_RD_LO:    begin mode_q <= MD_READ; col_q <= '0; end
        CMD_RD_HI:    begin mode_q <= MD_READ; col_q <= COL_W'(256); end
        CMD_RD_SPARE: begin mode_q <= MD_READ; col_q <= COL_W'(PAGE_SIZE); end
        CMD_RST:      begin mode_q <= MD_READ; col_q <= '0; end
        CMD_IDENT:    mode_q <= MD_IDENT;
        CMD_STAT:     mode_q <= MD_STAT;
        CMD_PG_SETUP: mode_q <= MD_PROG;
        CMD_ER_SETUP: mode_q <= MD_ERASE;
        default:      mode_q <= MD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_read_o    <= 1'b0;
      start_program_o <= 1'b0;
      start_erase_o   <= 1'b0;
      op_addr_o       <= '0;
      op_col_o        <= '0;
    end else begin
      start_read_o    <= go_read;
      start_program_o <= go_prog;
      start_erase_o   <= go_erase;
      if (go_read || go_prog || go_erase) op_col_o <= col_q;
      if (go_read)       op_addr_o <= addr_nxt;
      else if (go_prog)  op_addr_o <= addr_cur;
      else if (go_erase) op_addr_o <= {addr_msk[AW-9:0], 8'h00};
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (stat_rd)                             rd_val = status;
    else if (rd_en && mode_q == MD_IDENT)    rd_val = id_byte;
    else if (rd_en && mode_q == MD_READ)     rd_val = buf_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) io_o <= 8'h00;
    else         io_o <= rd_val;
  end

  assign buf_rd_o = rd_en && mode_q == MD_READ;
endmodule

// File: rtl/nand_cmd_frontend_chk.sv
module nand_cmd_frontend_chk #(
  parameter int ADDR_CYCLES = 3,
  parameter int CNT_W       = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             re_i,
  input logic             wp_ni,
  input logic [7:0]       io_o,
  input logic             start_read_o,
  input logic             start_program_o,
  input logic             start_erase_o,
  input logic             cmd_stb_i,
  input logic             stat_rd_i,
  input logic [CNT_W-1:0] cnt_i
);
  p_one_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_read_o, start_program_o, start_erase_o}));

  p_prog_needs_wp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_program_o |-> $past(wp_ni));

  p_erase_needs_wp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_erase_o |-> $past(wp_ni));

  p_read_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_read_o |=> !start_read_o);

  p_read_at_cnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_read_o |-> cnt_i == CNT_W'(ADDR_CYCLES));

  p_cmd_clears_cnt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_i |=> cnt_i == '0);

  p_status_wp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> io_o[7] == $past(wp_ni));

  p_ce_high_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && ce_ni) |=> io_o == 8'h00);
endmodule

bind nand_cmd_frontend nand_cmd_frontend_chk #(
  .ADDR_CYCLES(ADDR_CYCLES), .CNT_W(CNT_W)
) u_chk (
  .clk_i, .rst_ni, .ce_ni, .re_i, .wp_ni, .io_o,
  .start_read_o, .start_program_o, .start_erase_o,
  .cmd_stb_i(cmd_stb),
  .stat_rd_i(stat_rd),
  .cnt_i    (addr_cnt)
);

// File: tb/nand_cmd_frontend_test.sv
`timescale 1ns/1ps
module nand_cmd_frontend_test;
  localparam logic [3:0] K_CMD = 4'd0, K_ADR = 4'd1, K_RD = 4'd2, K_PUL = 4'd3;
  localparam int NV = 33;
  // {kind, req, data, expected}; K_PUL: data = flags {erase,prog,read}, expected = op_addr
  localparam logic [47:0] VEC [NV] = '{
    {K_CMD, 4'd5, 8'h90, 32'h0},          // R5 ident
    {K_ADR, 4'd5, 8'h00, 32'h0},
    {K_PUL, 4'd5, 8'h00, 32'h0},
    {K_RD,  4'd5, 8'h00, 32'hEC},
    {K_RD,  4'd5, 8'h00, 32'h73},
    {K_RD,  4'd5, 8'h00, 32'hA5},
    {K_RD,  4'd5, 8'h00, 32'hC0},
    {K_RD,  4'd5, 8'h00, 32'h00},
    {K_CMD, 4'd6, 8'h70, 32'h0},          // R6 status layout
    {K_RD,  4'd6, 8'h00, 32'hC0},
    {K_RD,  4'd7, 8'h00, 32'hC0},         // R7 repeat
    {K_CMD, 4'd2, 8'h00, 32'h0},          // R2 read
    {K_ADR, 4'd3, 8'h11, 32'h0},          // R3 lane order
    {K_PUL, 4'd4, 8'h00, 32'h0},
    {K_ADR, 4'd3, 8'h22, 32'h0},
    {K_PUL, 4'd4, 8'h00, 32'h0},
    {K_ADR, 4'd3, 8'h33, 32'h0},
    {K_PUL, 4'd4, 8'h01, 32'h00332211},   // R4
    {K_RD,  4'd2, 8'h00, 32'h3C},
    {K_CMD, 4'd9, 8'h60, 32'h0},          // R9 erase masking
    {K_ADR, 4'd9, 8'h44, 32'h0},
    {K_ADR, 4'd9, 8'h55, 32'h0},
    {K_CMD, 4'd9, 8'hD0, 32'h0},
    {K_PUL, 4'd9, 8'h04, 32'h00554400},
    {K_CMD, 4'd12, 8'h70, 32'h0},         // R12 busy after start
    {K_RD,  4'd12, 8'h00, 32'h80},
    {K_CMD, 4'd8, 8'h80, 32'h0},          // R8 program
    {K_ADR, 4'd8, 8'h01, 32'h0},
    {K_ADR, 4'd8, 8'h02, 32'h0},
    {K_ADR, 4'd8, 8'h03, 32'h0},
    {K_PUL, 4'd8, 8'h00, 32'h0},
    {K_CMD, 4'd8, 8'h10, 32'h0},
    {K_PUL, 4'd8, 8'h02, 32'h00030201}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, wp_n = 1'b1, we = 1'b0, re = 1'b0;
  logic [7:0] io_in = 8'h00, buf_data = 8'h3C;
  logic op_done = 1'b0, op_fail = 1'b0;
  logic [7:0] io_out;
  logic buf_rd, s_rd, s_pg, s_er;
  logic [31:0] op_addr;
  logic [9:0] op_col;

  int n_chk = 0, n_bad = 0;
  logic [2:0]  last_flags;
  logic [31:0] last_addr;
  logic [9:0]  last_col;
  logic [7:0]  rd_byte;
  bit done = 0;

  always #2.5 clk = ~clk;

  nand_cmd_frontend uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .wp_ni(wp_n), .we_i(we), .re_i(re), .io_i(io_in), .io_o(io_out),
    .buf_data_i(buf_data), .buf_rd_o(buf_rd), .op_done_i(op_done),
    .op_fail_i(op_fail), .start_read_o(s_rd), .start_program_o(s_pg),
    .start_erase_o(s_er), .op_addr_o(op_addr), .op_col_o(op_col)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic grab;
    last_flags = {s_er, s_pg, s_rd};
    last_addr  = op_addr;
    last_col   = op_col;
  endtask

  task automatic cyc_cmd(input logic [7:0] b);
    @(negedge clk); ce_n = 1'b0; cle = 1'b1; we = 1'b1; io_in = b;
    @(negedge clk); cle = 1'b0; we = 1'b0; io_in = 8'h00;
    grab();
  endtask

  task automatic cyc_adr(input logic [7:0] b);
    @(negedge clk); ce_n = 1'b0; ale = 1'b1; we = 1'b1; io_in = b;
    @(negedge clk); ale = 1'b0; we = 1'b0; io_in = 8'h00;
    grab();
  endtask

  task automatic cyc_rd;
    @(negedge clk); re = 1'b1;
    @(negedge clk); re = 1'b0;
    rd_byte = io_out;
  endtask

  task automatic pulse_in(input bit fail);
    @(negedge clk); op_done = !fail; op_fail = fail;
    @(negedge clk); op_done = 1'b0; op_fail = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act %h exp %h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(io_out == 8'h00, "R10", {24'h0, io_out}, 32'h0);
    chk({s_er, s_pg, s_rd} == 3'b000, "R10", {29'h0, s_er, s_pg, s_rd}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  k;
      logic [3:0]  rq;
      logic [7:0]  d;
      logic [31:0] e;
      {k, rq, d, e} = VEC[i];
      case (k)
        K_CMD: cyc_cmd(d);
        K_ADR: cyc_adr(d);
        K_RD: begin
          cyc_rd();
          chk(rd_byte == e[7:0], $sformatf("R%0d", rq), {24'h0, rd_byte}, e);
        end
        default: begin
          chk(last_flags == d[2:0], $sformatf("R%0d", rq), {29'h0, last_flags}, {29'h0, d[2:0]});
          if (d[2:0] != 3'b000)
            chk(last_addr == e, $sformatf("R%0d", rq), last_addr, e);
        end
      endcase
    end

    // R12: done sets ready, fail sets error
    pulse_in(1'b0);
    cyc_cmd(8'h70); cyc_rd();
    chk(rd_byte == 8'hC0, "R12", {24'h0, rd_byte}, 32'hC0);
    pulse_in(1'b1);
    cyc_rd();
    chk(rd_byte == 8'hC1, "R12", {24'h0, rd_byte}, 32'hC1);

    // R12: reset command and failure report on the same edge
    @(negedge clk); ce_n = 1'b0; cle = 1'b1; we = 1'b1; io_in = 8'hFF; op_fail = 1'b1;
    @(negedge clk); cle = 1'b0; we = 1'b0; io_in = 8'h00; op_fail = 1'b0;
    cyc_cmd(8'h70); cyc_rd();
    chk(rd_byte == 8'hC0, "R12", {24'h0, rd_byte}, 32'hC0);

    // R6: protect bit is live
    wp_n = 1'b0;
    cyc_rd();
    chk(rd_byte == 8'h40, "R6", {24'h0, rd_byte}, 32'h40);
    wp_n = 1'b1;
    cyc_rd();
    chk(rd_byte == 8'hC0, "R6", {24'h0, rd_byte}, 32'hC0);

    // R8: protected program and erase are dropped
    wp_n = 1'b0;
    cyc_cmd(8'h80); cyc_adr(8'h01); cyc_adr(8'h02); cyc_adr(8'h03);
    cyc_cmd(8'h10);
    chk(last_flags == 3'b000, "R8", {29'h0, last_flags}, 32'h0);
    cyc_cmd(8'h60); cyc_adr(8'h01); cyc_adr(8'h02);
    cyc_cmd(8'hD0);
    chk(last_flags == 3'b000, "R8", {29'h0, last_flags}, 32'h0);
    wp_n = 1'b1;
    cyc_cmd(8'h70); cyc_rd();
    chk(rd_byte == 8'hC0, "R8", {24'h0, rd_byte}, 32'hC0);

    // R2: pointer commands and their offsets
    cyc_cmd(8'h01); cyc_adr(8'h01); cyc_adr(8'h02); cyc_adr(8'h03);
    chk(last_flags == 3'b001 && last_col == 10'h100, "R2", {22'h0, last_col}, 32'h100);
    cyc_cmd(8'h50); cyc_adr(8'h01); cyc_adr(8'h02); cyc_adr(8'h03);
    chk(last_flags == 3'b001 && last_col == 10'h200, "R2", {22'h0, last_col}, 32'h200);
    cyc_cmd(8'h00); cyc_adr(8'h01); cyc_adr(8'h02); cyc_adr(8'h03);
    chk(last_flags == 3'b001 && last_col == 10'h000, "R2", {22'h0, last_col}, 32'h0);

    // R3: a new command restarts the cycle count
    cyc_cmd(8'h00); cyc_adr(8'hAA); cyc_adr(8'hBB);
    cyc_cmd(8'h00); cyc_adr(8'h04);
    chk(last_flags == 3'b000, "R3", {29'h0, last_flags}, 32'h0);
    cyc_adr(8'h05);
    chk(last_flags == 3'b000, "R3", {29'h0, last_flags}, 32'h0);
    cyc_adr(8'h06);
    chk(last_flags == 3'b001 && last_addr == 32'h00060504, "R3", last_addr, 32'h00060504);

    // R1: command byte with CE high or without strobe is ignored
    @(negedge clk); ce_n = 1'b1; cle = 1'b1; we = 1'b1; io_in = 8'h70;
    @(negedge clk); we = 1'b0; ce_n = 1'b0;
    @(negedge clk); cle = 1'b0; io_in = 8'h00;
    cyc_rd();
    chk(rd_byte == 8'h3C, "R1", {24'h0, rd_byte}, 32'h3C);

    // R11: CE-high read returns zero and does not advance
    cyc_cmd(8'h90); cyc_adr(8'h00);
    cyc_rd();
    chk(rd_byte == 8'hEC, "R11", {24'h0, rd_byte}, 32'hEC);
    @(negedge clk); ce_n = 1'b1; re = 1'b1;
    @(negedge clk); re = 1'b0; rd_byte = io_out; ce_n = 1'b0;
    chk(rd_byte == 8'h00, "R11", {24'h0, rd_byte}, 32'h0);
    cyc_rd();
    chk(rd_byte == 8'h73, "R11", {24'h0, rd_byte}, 32'h73);

    // R10: reset command clears offset and address
    cyc_cmd(8'h50); cyc_cmd(8'hFF);
    cyc_adr(8'h07); cyc_adr(8'h08); cyc_adr(8'h09);
    chk(last_flags == 3'b001 && last_col == 10'h000, "R10", {22'h0, last_col}, 32'h0);
    chk(last_addr == 32'h00090807, "R10", last_addr, 32'h00090807);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule